// File: doc/BRIEF.md
# Centered binomial noise sampler

This block turns a stream of pseudorandom bytes into the coefficients of a noise polynomial whose values follow a centered binomial distribution with a selectable width of two or three. Software or a sequencing engine pulses a start input together with a width select. The block then pulls exactly 64 input words over a ready/valid channel and returns 64 output beats of four coefficients each, which makes one 256-coefficient polynomial.

Every coefficient is the number of ones in one group of random bits minus the number of ones in the next group of the same size. The result is handed out already reduced into the range 0..3328, so a negative value appears as 3329 minus its magnitude. The datapath is a fixed network of bit counters. The number of cycles and the handshake pattern depend only on the two handshakes, never on the random values. A register on the output side absorbs backpressure. Input words are taken only when that register has room, so no bit is lost or repeated.

The input word is 24 bits wide and its first byte sits in bits 7:0. In width-three mode all 24 bits are used. In width-two mode only bits 15:0 are used, so a polynomial needs 192 or 128 bytes.

Top module: `cbd_sampler`

## Requirements
- R1: After reset `out_valid_o`, `out_last_o` and `in_ready_o` are 0, and `in_ready_o` stays 0 while no polynomial has been started.
- R2: A `start_i` pulse while idle begins a polynomial. In the following cycle `in_ready_o` is 1 as long as the output register is empty or `out_ready_i` is 1.
- R3: With width two (`eta_hi_i`=0 latched at start), lane k of a beat (bits 12k+11:12k of `out_coef_o`) equals popcount(word[4k+1:4k]) minus popcount(word[4k+3:4k+2]), and bits 23:16 of the word have no effect.
- R4: With width three (`eta_hi_i`=1 latched at start), lane k equals popcount(word[6k+2:6k]) minus popcount(word[6k+5:6k+3]).
- R5: A negative lane value d is emitted as the 12-bit value 3329+d. Every valid lane therefore lies in 0..3 or 3326..3328.
- R6: Each polynomial accepts exactly 64 input words and emits exactly 64 beats, in input order. `out_last_o` is 1 on the 64th beat only. After that `in_ready_o` is 0 until the next start.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, the output beat stays unchanged and `in_ready_o` is 0.
- R8: `start_i` and `eta_hi_i` are ignored while a polynomial is in progress. The width latched at start holds until the 64th word.
- R9: With `in_valid_i` and `out_ready_i` held at 1, a word is taken every cycle and the last beat is handed over 65 cycles after the first word is offered, whatever the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a polynomial (sampled only when idle) |
| eta_hi_i | input | 1 | Width select: 0 = two, 1 = three (sampled with start) |
| in_valid_i | input | 1 | Random word valid |
| in_data_i | input | 24 | Random word, first byte in bits 7:0 |
| in_ready_o | output | 1 | Block takes the word this cycle |
| out_valid_o | output | 1 | Output beat valid |
| out_coef_o | output | 48 | Four 12-bit coefficients, lane k in bits 12k+11:12k |
| out_last_o | output | 1 | Marks the 64th beat of a polynomial |
| out_ready_i | input | 1 | Consumer takes the beat this cycle |

## Verification
The two functions that can meet in one cycle are the release of a held output beat and the capture of the next input word into the same register. When `out_ready_i` returns high, the stalled beat leaves and a fresh word is loaded at the same edge. The bench provokes this with out-of-phase gaps on `in_valid_i` and `out_ready_i`. It judges the result by pairing every handed-over beat with the word of the same index, so a dropped or doubled beat shows up as a mismatch, a misplaced last marker or a wrong word count. A second overlap, a start pulse in the middle of a polynomial while the width select flips, is judged by the coefficients and the position of the last marker.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  // Ring modulus the coefficients are reduced into
  localparam int unsigned CBD_Q       = 3329;
  // Largest supported binomial width; the small mode is one less
  localparam int unsigned CBD_ETA_MAX = 3;
  localparam int unsigned CBD_COEF_W  = 12;
  localparam int unsigned CBD_LANES   = 4;
  localparam int unsigned CBD_N_COEF  = 256;
endpackage

// File: rtl/cbd_rst_sync.sv
module cbd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/cbd_lane.sv
module cbd_lane #(
  parameter int unsigned ETA_MAX = 3,
  parameter int unsigned COEF_W  = 12,
  parameter int unsigned Q       = 3329,
  localparam int unsigned GRP_W  = 2 * ETA_MAX,
  localparam int unsigned CNT_W  = $clog2(ETA_MAX + 1)
) (
  input  logic              eta_hi_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [COEF_W-1:0] coef_o
);
  logic [CNT_W-1:0] pos_cnt, neg_cnt;

  // Parallel bit counting: both halves are counted in the same cycle
  always_comb begin
    pos_cnt = '0;
    neg_cnt = '0;
    for (int j = 0; j < ETA_MAX; j++) begin
      if (eta_hi_i) begin
        pos_cnt = pos_cnt + CNT_W'(grp_i[j]);
        neg_cnt = neg_cnt + CNT_W'(grp_i[ETA_MAX + j]);
      end else if (j < ETA_MAX - 1) begin
        pos_cnt = pos_cnt + CNT_W'(grp_i[j]);
        neg_cnt = neg_cnt + CNT_W'(grp_i[ETA_MAX - 1 + j]);
      end
    end
  end

  // Reduce into 0..Q-1 without a branch on the data's timing
  always_comb begin
    if (pos_cnt >= neg_cnt) coef_o = COEF_W'(pos_cnt - neg_cnt);
    else                    coef_o = COEF_W'(Q) - COEF_W'(neg_cnt - pos_cnt);
  end
endmodule

// File: rtl/cbd_ctrl.sv
module cbd_ctrl #(
  parameter int unsigned BEATS = 64,
  localparam int unsigned CNT_W = $clog2(BEATS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic eta_hi_i,
  input  logic in_valid_i,
  input  logic room_i,
  output logic busy_o,
  output logic eta_hi_o,
  output logic in_ready_o,
  output logic load_o,
  output logic last_beat_o
);
  logic             busy_q, busy_d;
  logic             eta_q, eta_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign in_ready_o  = busy_q & room_i;
  assign load_o      = in_ready_o & in_valid_i;
  assign last_beat_o = (cnt_q == CNT_W'(BEATS - 1));

  always_comb begin
    busy_d = busy_q;
    eta_d  = eta_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        eta_d  = eta_hi_i;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    end else if (load_o) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
      if (last_beat_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      eta_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) begin
        eta_q <= eta_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o   = busy_q;
  assign eta_hi_o = eta_q;
endmodule

// File: rtl/cbd_outreg.sv
module cbd_outreg #(
  parameter int unsigned DATA_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              out_ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              room_o
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q;
  logic              last_q;

  assign room_o = !valid_q || out_ready_i;

  always_comb begin
    valid_d = valid_q;
    if (load_i)           valid_d = 1'b1;
    else if (out_ready_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  // Payload needs no reset: it is qualified by valid_q
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      data_q <= data_i;
      last_q <= last_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = valid_q & last_q;
endmodule

// File: rtl/cbd_sampler.sv
module cbd_sampler
  import cbd_pkg::*;
#(
  parameter int unsigned LANES   = CBD_LANES,
  parameter int unsigned ETA_MAX = CBD_ETA_MAX,
  parameter int unsigned COEF_W  = CBD_COEF_W,
  parameter int unsigned Q       = CBD_Q,
  parameter int unsigned N_COEF  = CBD_N_COEF,
  localparam int unsigned GRP_W  = 2 * ETA_MAX,
  localparam int unsigned LO_W   = 2 * (ETA_MAX - 1),
  localparam int unsigned IN_W   = LANES * GRP_W,
  localparam int unsigned OUT_W  = LANES * COEF_W,
  localparam int unsigned BEATS  = N_COEF / LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             eta_hi_i,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_coef_o,
  output logic             out_last_o,
  input  logic             out_ready_i
);
  logic             rst_sync_n;
  logic             busy;
  logic             eta_hi;
  logic             room;
  logic             load;
  logic             last_beat;
  logic [OUT_W-1:0] coef_vec;

  cbd_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cbd_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .start_i     (start_i),
    .eta_hi_i    (eta_hi_i),
    .in_valid_i  (in_valid_i),
    .room_i      (room),
    .busy_o      (busy),
    .eta_hi_o    (eta_hi),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .last_beat_o (last_beat)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [GRP_W-1:0] grp;
    // Wide mode slices 2*ETA_MAX bits per lane, narrow mode 2*(ETA_MAX-1)
    assign grp = eta_hi ? in_data_i[k*GRP_W +: GRP_W]
                        : GRP_W'(in_data_i[k*LO_W +: LO_W]);
    cbd_lane #(.ETA_MAX(ETA_MAX), .COEF_W(COEF_W), .Q(Q)) u_lane (
      .eta_hi_i (eta_hi),
      .grp_i    (grp),
      .coef_o   (coef_vec[k*COEF_W +: COEF_W])
    );
  end

  cbd_outreg #(.DATA_W(OUT_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .load_i      (load),
    .data_i      (coef_vec),
    .last_i      (last_beat),
    .out_ready_i (out_ready_i),
    .valid_o     (out_valid_o),
    .data_o      (out_coef_o),
    .last_o      (out_last_o),
    .room_o      (room)
  );
endmodule

// File: rtl/cbd_sampler_chk.sv
module cbd_sampler_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned ETA_MAX = 3,
  parameter int unsigned COEF_W  = 12,
  parameter int unsigned Q       = 3329,
  parameter int unsigned BEATS   = 64,
  localparam int unsigned OUT_W  = LANES * COEF_W,
  localparam int unsigned CNT_W  = $clog2(BEATS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             eta_hi,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [OUT_W-1:0] out_coef
);
  logic [CNT_W-1:0] beat_cnt;

  // Independent count of beats handed over within the current polynomial
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_cnt <= '0;
    else if (out_valid && out_ready) beat_cnt <= out_last ? '0 : beat_cnt + 1'b1;
  end

  a_r1_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  a_r7_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_coef) && $stable(out_last));

  a_r7_no_take_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r6_last_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> beat_cnt == CNT_W'(BEATS - 1));

  a_r6_count_gives_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && beat_cnt == CNT_W'(BEATS - 1) |-> out_last);

  a_r8_width_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(eta_hi));

  for (genvar k = 0; k < LANES; k++) begin : g_rng
    a_r5_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_coef[k*COEF_W +: COEF_W] <= COEF_W'(ETA_MAX)) ||
                    (out_coef[k*COEF_W +: COEF_W] >= COEF_W'(Q - ETA_MAX)));
  end
endmodule

bind cbd_sampler cbd_sampler_chk #(
  .LANES(LANES), .ETA_MAX(ETA_MAX), .COEF_W(COEF_W), .Q(Q), .BEATS(BEATS)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .eta_hi    (eta_hi),
  .in_ready  (in_ready_o),
  .out_valid (out_valid_o),
  .out_ready (out_ready_i),
  .out_last  (out_last_o),
  .out_coef  (out_coef_o)
);

// File: tb/tb_cbd_sampler.sv
`timescale 1ns/1ps
module tb_cbd_sampler;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i, eta_hi_i, in_valid_i, out_ready_i;
  logic [23:0] in_data_i;
  logic        in_ready_o, out_valid_o, out_last_o;
  logic [47:0] out_coef_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cbd_sampler dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .eta_hi_i(eta_hi_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_coef_o(out_coef_o), .out_last_o(out_last_o),
    .out_ready_i(out_ready_i)
  );

  // {width-three flag, input word, expected lanes 3..0}
  localparam logic [72:0] VEC [0:9] = '{
    {1'b0, 24'h000000, 12'd0,    12'd0,    12'd0, 12'd0},
    {1'b0, 24'h000003, 12'd0,    12'd0,    12'd0, 12'd2},
    {1'b0, 24'h00000C, 12'd0,    12'd0,    12'd0, 12'd3327},
    {1'b0, 24'hFFFF00, 12'd0,    12'd0,    12'd0, 12'd0},
    {1'b0, 24'hAB1C36, 12'd1,    12'd3327, 12'd2, 12'd0},
    {1'b1, 24'h000007, 12'd0,    12'd0,    12'd0, 12'd3},
    {1'b1, 24'hE00000, 12'd3326, 12'd0,    12'd0, 12'd0},
    {1'b1, 24'h5AC396, 12'd1,    12'd3328, 12'd1, 12'd1},
    {1'b0, 24'h5AC396, 12'd3327, 12'd2,    12'd0, 12'd0},
    {1'b1, 24'hFFFFFF, 12'd0,    12'd0,    12'd0, 12'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] word_of(input int idx, input int seed);
    logic [31:0] h;
    h = (32'(idx) * 32'h9E3779B1) ^ 32'(seed);
    h = h ^ (h >> 13);
    return h[27:4];
  endfunction

  // Reference built from the requirement text, lane by lane
  function automatic logic [47:0] model(input logic hi, input logic [23:0] w);
    logic [47:0] r;
    int n, a, b, d;
    n = hi ? 3 : 2;
    for (int k = 0; k < 4; k++) begin
      a = 0; b = 0;
      for (int j = 0; j < n; j++) begin
        a += int'(w[2*n*k + j]);
        b += int'(w[2*n*k + n + j]);
      end
      d = a - b;
      r[k*12 +: 12] = (d < 0) ? 12'(3329 + d) : 12'(d);
    end
    return r;
  endfunction

  task automatic run_poly(input logic hi, input bit fixed, input logic [23:0] fdata,
                          input logic [47:0] fexp, input int mode, input int seed,
                          input bit mid, input bit chk_time, input string req);
    int in_idx = 0;
    int ob = 0;
    int it = 0;
    logic [47:0] held = '0;
    logic held_v = 1'b0;
    logic [47:0] ex;
    @(negedge clk_i);
    start_i = 1'b1; eta_hi_i = hi; in_valid_i = 1'b0; out_ready_i = 1'b0;
    while (ob < 64 && it < 3000) begin
      @(negedge clk_i);
      it++;
      start_i    = mid && (ob == 10);
      eta_hi_i   = mid ? ~hi : hi;
      in_valid_i = (mode == 0) ? 1'b1 : ((it % 5) != 2);
      out_ready_i = (mode == 0) ? 1'b1 : ((it % 3) != 0);
      in_data_i  = fixed ? fdata : word_of(in_idx, seed);
      #1;
      if (it == 1) chk(in_ready_o, "R2", "ready after start", 48'(in_ready_o), 48'd1);
      if (held_v) chk(out_valid_o && out_coef_o == held, "R7", "stalled beat changed",
                      out_coef_o, held);
      if (out_valid_o && !out_ready_i && in_ready_o)
        chk(1'b0, "R7", "word taken while blocked", 48'(in_ready_o), 48'd0);
      if (out_valid_o && out_ready_i) begin
        ex = fixed ? fexp : model(hi, word_of(ob, seed));
        chk(out_coef_o == ex, req, $sformatf("beat %0d coefficients", ob), out_coef_o, ex);
        chk(out_last_o == (ob == 63), "R6", $sformatf("last flag beat %0d", ob),
            48'(out_last_o), 48'(ob == 63));
        ob++;
      end
      held_v = out_valid_o && !out_ready_i;
      held   = out_coef_o;
      if (in_valid_i && in_ready_o) in_idx++;
    end
    start_i = 1'b0; in_valid_i = 1'b1; out_ready_i = 1'b1;
    chk(ob == 64, "R6", "beats per polynomial", 48'(ob), 48'd64);
    chk(in_idx == 64, "R6", "words per polynomial", 48'(in_idx), 48'd64);
    if (chk_time) chk(it == 65, "R9", "cycles per polynomial", 48'(it), 48'd65);
    @(negedge clk_i); #1;
    chk(!in_ready_o && !out_valid_o, "R6", "idle after polynomial",
        {46'd0, in_ready_o, out_valid_o}, 48'd0);
    in_valid_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; eta_hi_i = 1'b0; in_valid_i = 1'b0;
    in_data_i = '0; out_ready_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!out_valid_o && !out_last_o && !in_ready_o, "R1", "reset state",
        {45'd0, out_valid_o, out_last_o, in_ready_o}, 48'd0);
    // R1: words offered without a start are never taken
    in_valid_i = 1'b1; out_ready_i = 1'b1; in_data_i = 24'h123456;
    repeat (4) @(negedge clk_i);
    #1;
    chk(!in_ready_o && !out_valid_o, "R1", "idle ignores input",
        {46'd0, in_ready_o, out_valid_o}, 48'd0);
    in_valid_i = 1'b0;

    // Vector table: one full polynomial per entry at full rate (R3 R4 R5 R9)
    for (int v = 0; v < 10; v++) begin
      run_poly(VEC[v][72], 1'b1, VEC[v][71:48], VEC[v][47:0], 0, 0, 1'b0, 1'b1,
               VEC[v][72] ? "R4/R5" : "R3/R5");
    end

    // Backpressure with gaps on both sides, varied data (R7 R6)
    run_poly(1'b0, 1'b0, '0, '0, 1, 32'h1357, 1'b0, 1'b0, "R3");
    run_poly(1'b1, 1'b0, '0, '0, 1, 32'h2468, 1'b0, 1'b0, "R4");
    // Start and width select toggled mid-polynomial (R8)
    run_poly(1'b0, 1'b0, '0, '0, 0, 32'h0ACE, 1'b1, 1'b1, "R8");
    run_poly(1'b1, 1'b0, '0, '0, 1, 32'h0BDF, 1'b1, 1'b0, "R8");
    // Constant timing with random data (R9)
    run_poly(1'b1, 1'b0, '0, '0, 0, 32'h7777, 1'b0, 1'b1, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule